// File: doc/BRIEF.md
# Raster Panel Timing Generator

This block produces the line sync, frame sync, data-enable and pixel clock for a raster display panel. All of them are derived from a single core clock. A programmable integer divisor turns the core clock into a one-cycle pixel enable, together with a square pixel clock for the panel pin. Two counters run on that enable, one per axis, and walk each line and each frame through four regions in turn: sync pulse, back porch, active video and front porch. Start-of-frame and end-of-frame strobes tell a downstream pixel fetcher when a frame begins and when it ends.

Software programs the timing fields while the raster is stopped and then raises the enable. The fields are copied into shadow registers when the raster starts, so writing them during active video changes nothing. Dropping the enable does not cut the picture. The current frame plays out to its last pixel, then the generator stops and raises a sticky done flag. Software clears that flag by pulsing a one on the clear input.

The active width is coded as groups of 16 pixels minus one, using a 6-bit field plus a separately stored seventh bit. The active height is coded as lines minus one, using a 10-bit field plus a separately stored eleventh bit.

Top module: `lcd_raster_timing`

## Requirements
- R1: The pixel enable is a single-cycle pulse every D core clocks, where D is the divisor field, and any divisor below 2 behaves as 2. The first pulse comes D clocks after the cycle in which the enable is sampled high. The uninverted pixel clock is high for the first floor(D/2) core clocks of each pixel period and low for the rest, so it is low in the cycle that carries the pixel enable.
- R2: Each line, counted in pixel enables, runs in this order: line sync for hsw+1 pixels, back porch for hbp+1, active video for (ppl+1)*16, then front porch for hfp+1. The uninverted line sync is high only during the sync region.
- R3: Each frame, counted in lines, runs in this order: frame sync for vsw+1 lines, back porch for vbp+1, active video for lpp+1 lines, then front porch for vfp+1. The uninverted frame sync is high only during its sync region.
- R4: Data-enable is high only when both the line position and the frame position are in their active regions, giving exactly width*height enabled pixels per frame.
- R5: The separate width extension bit adds 1024 active pixels per line, and the separate height extension bit adds 1024 active lines per frame.
- R6: Three independent inputs invert the pixel clock, the line sync and the frame sync. While stopped, each of these outputs sits at the level of its invert bit.
- R7: The start-of-frame strobe marks the pixel enable of the first pixel of the first line, and the end-of-frame strobe marks the pixel enable of the last pixel of the last line. Neither strobe appears in any other cycle.
- R8: When the raster enable is cleared mid-frame, the frame completes. The done flag is high in the cycle after the end-of-frame strobe, and no further pixel enables follow.
- R9: The done flag stays set while stopped. A one-cycle pulse on the clear input drops it on the next clock.
- R10: Divisor and timing fields changed while the raster runs have no effect on the frame in progress.
- R11: After reset the done flag, pixel enable, data-enable and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| raster_en_i | input | 1 | Run request; dropping it finishes the current frame |
| done_clr_i | input | 1 | Pulse to clear the done flag |
| clk_div_i | input | DIV_W | Core clocks per pixel (values below 2 act as 2) |
| hsw_i | input | SW_W | Line sync width minus one |
| hbp_i | input | PORCH_W | Line back porch minus one |
| hfp_i | input | PORCH_W | Line front porch minus one |
| ppl_lo_i | input | PPL_LO_W | Active width in groups of 16, minus one, low bits |
| ppl_hi_i | input | 1 | Width extension bit (weight 64 groups) |
| vsw_i | input | SW_W | Frame sync width in lines minus one |
| vbp_i | input | PORCH_W | Frame back porch minus one |
| vfp_i | input | PORCH_W | Frame front porch minus one |
| lpp_lo_i | input | LPP_LO_W | Active lines minus one, low bits |
| lpp_hi_i | input | 1 | Height extension bit (weight 1024 lines) |
| inv_pclk_i | input | 1 | Invert pixel clock |
| inv_hsync_i | input | 1 | Invert line sync |
| inv_vsync_i | input | 1 | Invert frame sync |
| pclk_o | output | 1 | Pixel clock to the panel |
| pix_en_o | output | 1 | One-cycle pixel enable |
| hsync_o | output | 1 | Line sync |
| vsync_o | output | 1 | Frame sync |
| de_o | output | 1 | Data enable |
| sof_o | output | 1 | Start-of-frame strobe |
| eof_o | output | 1 | End-of-frame strobe |
| frame_done_o | output | 1 | Sticky stop-complete flag |

## Verification
The bench builds the block with its default parameters: an 8-bit divisor, 6-bit sync widths, 8-bit porches and both extension bits enabled. This lets it reach a 1040-pixel line and a 1025-line frame, as well as porches and sync widths at their maximum field values, each within a few tens of thousands of clocks. Divisors of 0, 1, 2, 3, 4 and 5 cover the clamp, the even and odd duty splits, and the start latency. Every frame is stopped right after its first pixel while the timing inputs are scrambled, so the drain path and the shadow copy are exercised on every vector.

// File: rtl/lcd_timing_pkg.sv
package lcd_timing_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2
  } raster_state_e;

  localparam int unsigned DIV_FLOOR    = 2;
  localparam int unsigned ACT_GRAIN_LG = 4;
endpackage

// File: rtl/lcd_pix_div.sv
module lcd_pix_div
  import lcd_timing_pkg::*;
#(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             pix_en_o,
  output logic             pclk_o
);
  logic [DIV_W-1:0] eff_q, eff_d, cnt_q;
  logic             wrap;

  assign eff_d = (div_i < DIV_W'(DIV_FLOOR)) ? DIV_W'(DIV_FLOOR) : div_i;
  assign wrap  = (cnt_q == eff_q - DIV_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eff_q <= DIV_W'(DIV_FLOOR);
      cnt_q <= '0;
    end else begin
      if (load_i) eff_q <= eff_d;
      if (!run_i)    cnt_q <= '0;
      else if (wrap) cnt_q <= '0;
      else           cnt_q <= cnt_q + DIV_W'(1);
    end
  end

  assign pix_en_o = run_i && wrap;
  // high phase first, so the enable lands in the low phase
  assign pclk_o   = run_i && (cnt_q < (eff_q >> 1));
endmodule

// File: rtl/lcd_axis_cnt.sv
module lcd_axis_cnt #(
  parameter int unsigned CNT_W   = 12,
  parameter int unsigned SW_W    = 6,
  parameter int unsigned PORCH_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               clear_i,
  input  logic               step_i,
  input  logic [SW_W-1:0]    sw_i,
  input  logic [PORCH_W-1:0] bp_i,
  input  logic [PORCH_W-1:0] fp_i,
  input  logic [CNT_W-1:0]   act_len_i,
  output logic               sync_o,
  output logic               act_o,
  output logic               first_o,
  output logic               last_o
);
  logic [CNT_W-1:0] sync_end_d, act_beg_d, act_end_d, last_d;
  logic [CNT_W-1:0] sync_end_q, act_beg_q, act_end_q, last_q;
  logic [CNT_W-1:0] cnt_q;

  // region boundaries precomputed at load to keep adders off the count path
  assign sync_end_d = CNT_W'(sw_i) + CNT_W'(1);
  assign act_beg_d  = sync_end_d + CNT_W'(bp_i) + CNT_W'(1);
  assign act_end_d  = act_beg_d + act_len_i;
  assign last_d     = act_end_d + CNT_W'(fp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_end_q <= '0;
      act_beg_q  <= '0;
      act_end_q  <= '0;
      last_q     <= '0;
    end else if (load_i) begin
      sync_end_q <= sync_end_d;
      act_beg_q  <= act_beg_d;
      act_end_q  <= act_end_d;
      last_q     <= last_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (clear_i)  cnt_q <= '0;
    else if (step_i)   cnt_q <= last_o ? '0 : cnt_q + CNT_W'(1);
  end

  assign sync_o  = cnt_q < sync_end_q;
  assign act_o   = (cnt_q >= act_beg_q) && (cnt_q < act_end_q);
  assign first_o = cnt_q == '0;
  assign last_o  = cnt_q == last_q;
endmodule

// File: rtl/lcd_raster_ctrl.sv
module lcd_raster_ctrl
  import lcd_timing_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic frame_end_i,
  input  logic done_clr_i,
  output logic load_o,
  output logic run_o,
  output logic done_o
);
  raster_state_e state_q, state_d;
  logic          done_set;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (en_i) state_d = ST_RUN;
      ST_RUN:   if (!en_i) state_d = frame_end_i ? ST_IDLE : ST_DRAIN;
      ST_DRAIN: if (frame_end_i) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  assign done_set = frame_end_i &&
                    ((state_q == ST_DRAIN) || ((state_q == ST_RUN) && !en_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_o  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (done_set)        done_o <= 1'b1;
      else if (done_clr_i) done_o <= 1'b0;
    end
  end

  assign load_o = (state_q == ST_IDLE) && en_i;
  assign run_o  = state_q != ST_IDLE;
endmodule

// File: rtl/lcd_raster_timing.sv
module lcd_raster_timing
  import lcd_timing_pkg::*;
#(
  parameter int unsigned DIV_W    = 8,
  parameter int unsigned SW_W     = 6,
  parameter int unsigned PORCH_W  = 8,
  parameter int unsigned PPL_LO_W = 6,
  parameter int unsigned LPP_LO_W = 10,
  parameter bit          PPL_EXT  = 1'b1,
  parameter bit          LPP_EXT  = 1'b1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                raster_en_i,
  input  logic                done_clr_i,
  input  logic [DIV_W-1:0]    clk_div_i,
  input  logic [SW_W-1:0]     hsw_i,
  input  logic [PORCH_W-1:0]  hbp_i,
  input  logic [PORCH_W-1:0]  hfp_i,
  input  logic [PPL_LO_W-1:0] ppl_lo_i,
  input  logic                ppl_hi_i,
  input  logic [SW_W-1:0]     vsw_i,
  input  logic [PORCH_W-1:0]  vbp_i,
  input  logic [PORCH_W-1:0]  vfp_i,
  input  logic [LPP_LO_W-1:0] lpp_lo_i,
  input  logic                lpp_hi_i,
  input  logic                inv_pclk_i,
  input  logic                inv_hsync_i,
  input  logic                inv_vsync_i,
  output logic                pclk_o,
  output logic                pix_en_o,
  output logic                hsync_o,
  output logic                vsync_o,
  output logic                de_o,
  output logic                sof_o,
  output logic                eof_o,
  output logic                frame_done_o
);
  localparam int unsigned PPL_W  = PPL_LO_W + 1;
  localparam int unsigned LPP_W  = LPP_LO_W + 1;
  localparam int unsigned H_MAX  = (1 << SW_W) + 2 * (1 << PORCH_W) + ((1 << PPL_W) << ACT_GRAIN_LG);
  localparam int unsigned V_MAX  = (1 << SW_W) + 2 * (1 << PORCH_W) + (1 << LPP_W);
  localparam int unsigned HCNT_W = $clog2(H_MAX + 1);
  localparam int unsigned VCNT_W = $clog2(V_MAX + 1);

  logic              load, run, pix_en, pclk_raw, frame_end;
  logic              h_sync, h_act, h_first, h_last;
  logic              v_sync, v_act, v_first, v_last;
  logic [PPL_W-1:0]  ppl_full;
  logic [LPP_W-1:0]  lpp_full;
  logic [HCNT_W-1:0] hact_len;
  logic [VCNT_W-1:0] vact_len;

  if (PPL_EXT) begin : g_ppl_ext
    assign ppl_full = {ppl_hi_i, ppl_lo_i};
  end else begin : g_ppl_base
    assign ppl_full = {1'b0, ppl_lo_i};
  end

  if (LPP_EXT) begin : g_lpp_ext
    assign lpp_full = {lpp_hi_i, lpp_lo_i};
  end else begin : g_lpp_base
    assign lpp_full = {1'b0, lpp_lo_i};
  end

  assign hact_len = (HCNT_W'(ppl_full) + HCNT_W'(1)) << ACT_GRAIN_LG;
  assign vact_len = VCNT_W'(lpp_full) + VCNT_W'(1);

  lcd_raster_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (raster_en_i),
    .frame_end_i (frame_end),
    .done_clr_i  (done_clr_i),
    .load_o      (load),
    .run_o       (run),
    .done_o      (frame_done_o)
  );

  lcd_pix_div #(.DIV_W(DIV_W)) u_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .run_i    (run),
    .div_i    (clk_div_i),
    .pix_en_o (pix_en),
    .pclk_o   (pclk_raw)
  );

  lcd_axis_cnt #(.CNT_W(HCNT_W), .SW_W(SW_W), .PORCH_W(PORCH_W)) u_hcnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .clear_i   (!run),
    .step_i    (pix_en),
    .sw_i      (hsw_i),
    .bp_i      (hbp_i),
    .fp_i      (hfp_i),
    .act_len_i (hact_len),
    .sync_o    (h_sync),
    .act_o     (h_act),
    .first_o   (h_first),
    .last_o    (h_last)
  );

  lcd_axis_cnt #(.CNT_W(VCNT_W), .SW_W(SW_W), .PORCH_W(PORCH_W)) u_vcnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .clear_i   (!run),
    .step_i    (pix_en && h_last),
    .sw_i      (vsw_i),
    .bp_i      (vbp_i),
    .fp_i      (vfp_i),
    .act_len_i (vact_len),
    .sync_o    (v_sync),
    .act_o     (v_act),
    .first_o   (v_first),
    .last_o    (v_last)
  );

  assign frame_end = pix_en && h_last && v_last;

  assign pix_en_o = pix_en;
  assign pclk_o   = pclk_raw ^ inv_pclk_i;
  assign hsync_o  = (run && h_sync) ^ inv_hsync_i;
  assign vsync_o  = (run && v_sync) ^ inv_vsync_i;
  assign de_o     = run && h_act && v_act;
  assign sof_o    = pix_en && h_first && v_first;
  assign eof_o    = frame_end;
endmodule

// File: rtl/lcd_raster_timing_chk.sv
module lcd_raster_timing_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic done_clr_i,
  input logic inv_hsync_i,
  input logic inv_vsync_i,
  input logic pix_en_o,
  input logic hsync_o,
  input logic vsync_o,
  input logic de_o,
  input logic sof_o,
  input logic eof_o,
  input logic frame_done_o
);
  // R1
  pix_en_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_en_o |=> !pix_en_o);

  // R4
  de_outside_sync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    de_o |-> (hsync_o == inv_hsync_i) && (vsync_o == inv_vsync_i));

  // R7
  strobe_on_pixel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sof_o || eof_o) |-> pix_en_o);

  // R8
  done_after_eof_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(frame_done_o) |-> $past(eof_o) && !pix_en_o);

  // R9
  done_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_clr_i && !eof_o) |=> !frame_done_o);
endmodule

bind lcd_raster_timing lcd_raster_timing_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .done_clr_i   (done_clr_i),
  .inv_hsync_i  (inv_hsync_i),
  .inv_vsync_i  (inv_vsync_i),
  .pix_en_o     (pix_en_o),
  .hsync_o      (hsync_o),
  .vsync_o      (vsync_o),
  .de_o         (de_o),
  .sof_o        (sof_o),
  .eof_o        (eof_o),
  .frame_done_o (frame_done_o)
);

// File: tb/lcd_raster_timing_tb_top.sv
module lcd_raster_timing_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 180000;
  localparam int NVEC       = 6;

  typedef struct packed {
    logic [7:0] div;
    logic [5:0] hsw;
    logic [7:0] hbp;
    logic [5:0] ppl;
    logic       ppl_x;
    logic [7:0] hfp;
    logic [5:0] vsw;
    logic [7:0] vbp;
    logic [9:0] lpp;
    logic       lpp_x;
    logic [7:0] vfp;
    logic [2:0] inv; // {pclk, hsync, vsync}
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{8'd0, 6'd0,  8'd0,   6'd0, 1'b0, 8'd0,   6'd0, 8'd0, 10'd3, 1'b0, 8'd0, 3'b000},
    '{8'd1, 6'd2,  8'd3,   6'd1, 1'b0, 8'd4,   6'd1, 8'd2, 10'd2, 1'b0, 8'd1, 3'b101},
    '{8'd5, 6'd5,  8'd1,   6'd0, 1'b0, 8'd2,   6'd2, 8'd0, 10'd1, 1'b0, 8'd3, 3'b010},
    '{8'd3, 6'd0,  8'd0,   6'd0, 1'b1, 8'd0,   6'd0, 8'd0, 10'd0, 1'b0, 8'd0, 3'b011},
    '{8'd2, 6'd0,  8'd0,   6'd0, 1'b0, 8'd0,   6'd0, 8'd0, 10'd0, 1'b1, 8'd0, 3'b110},
    '{8'd4, 6'd63, 8'd255, 6'd0, 1'b0, 8'd255, 6'd0, 8'd0, 10'd1, 1'b0, 8'd0, 3'b001}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       raster_en = 1'b0, done_clr = 1'b0;
  logic [7:0] clk_div = '0;
  logic [5:0] hsw = '0, vsw = '0, ppl_lo = '0;
  logic [7:0] hbp = '0, hfp = '0, vbp = '0, vfp = '0;
  logic [9:0] lpp_lo = '0;
  logic       ppl_hi = 1'b0, lpp_hi = 1'b0;
  logic       inv_p = 1'b0, inv_h = 1'b0, inv_v = 1'b0;
  logic       pclk, pix_en, hsync, vsync, de, sof, eof, done;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  lcd_raster_timing dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .raster_en_i  (raster_en),
    .done_clr_i   (done_clr),
    .clk_div_i    (clk_div),
    .hsw_i        (hsw),
    .hbp_i        (hbp),
    .hfp_i        (hfp),
    .ppl_lo_i     (ppl_lo),
    .ppl_hi_i     (ppl_hi),
    .vsw_i        (vsw),
    .vbp_i        (vbp),
    .vfp_i        (vfp),
    .lpp_lo_i     (lpp_lo),
    .lpp_hi_i     (lpp_hi),
    .inv_pclk_i   (inv_p),
    .inv_hsync_i  (inv_h),
    .inv_vsync_i  (inv_v),
    .pclk_o       (pclk),
    .pix_en_o     (pix_en),
    .hsync_o      (hsync),
    .vsync_o      (vsync),
    .de_o         (de),
    .sof_o        (sof),
    .eof_o        (eof),
    .frame_done_o (done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_vec(input int idx);
    vec_t c = VECS[idx];
    int eff = (c.div < 2) ? 2 : int'(c.div);
    int hs = int'(c.hsw) + 1, hb = int'(c.hbp) + 1, hf = int'(c.hfp) + 1;
    int ha = (int'({c.ppl_x, c.ppl}) + 1) * 16;
    int vs = int'(c.vsw) + 1, vb = int'(c.vbp) + 1, vf = int'(c.vfp) + 1;
    int va = int'({c.lpp_x, c.lpp}) + 1;
    int htot = hs + hb + ha + hf;
    int vtot = vs + vb + va + vf;
    int h = 0, v = 0, gap = 0, de_cnt = 0;
    int e_per = 0, e_pc = 0, e_h = 0, e_v = 0, e_de = 0, e_se = 0, extra = 0;
    bit prev_pe = 0, first = 1, finished = 0;
    bit ehs, evs, ede, esof, eeof;

    @(negedge clk);
    clk_div = c.div; hsw = c.hsw; hbp = c.hbp; hfp = c.hfp;
    ppl_lo = c.ppl; ppl_hi = c.ppl_x; vsw = c.vsw; vbp = c.vbp; vfp = c.vfp;
    lpp_lo = c.lpp; lpp_hi = c.lpp_x;
    {inv_p, inv_h, inv_v} = c.inv;
    done_clr = 1'b1;
    @(negedge clk);
    done_clr = 1'b0;
    chk(done == 1'b0, "R9 clear", int'(done), 0);
    // R6 idle levels follow the invert inputs
    chk({pclk, hsync, vsync} == c.inv, "R6 idle levels", int'({pclk, hsync, vsync}), int'(c.inv));

    raster_en = 1'b1;
    while (!finished) begin
      @(negedge clk);
      gap++;
      if (prev_pe && (pclk != !inv_p)) e_pc++;
      if (pix_en) begin
        if (gap != eff) e_per++;
        gap = 0;
        if (pclk != inv_p) e_pc++;
        ehs  = (h < hs) ^ inv_h;
        evs  = (v < vs) ^ inv_v;
        ede  = (h >= hs + hb) && (h < hs + hb + ha) && (v >= vs + vb) && (v < vs + vb + va);
        esof = (h == 0) && (v == 0);
        eeof = (h == htot - 1) && (v == vtot - 1);
        if (hsync != ehs) e_h++;
        if (vsync != evs) e_v++;
        if (de != ede) e_de++;
        if (de) de_cnt++;
        if ((sof != esof) || (eof != eeof)) e_se++;
        if (first) begin
          // R10 scramble timing while running; R8 request stop mid-frame
          raster_en = 1'b0;
          clk_div = 8'd7; hsw = '1; hbp = 8'h55; hfp = 8'h0f; ppl_lo = '1; ppl_hi = 1'b1;
          vsw = 6'd9; vbp = 8'h21; vfp = 8'h3c; lpp_lo = '1; lpp_hi = 1'b1;
          first = 0;
        end
        if (eeof) finished = 1;
        if (h == htot - 1) begin
          h = 0;
          v = (v == vtot - 1) ? 0 : v + 1;
        end else begin
          h++;
        end
      end else if (sof || eof) begin
        e_se++;
      end
      prev_pe = pix_en;
    end

    chk(e_per == 0, "R1 pixel period", e_per, 0);
    chk(e_pc == 0, "R1 R6 pixel clock phase", e_pc, 0);
    chk(e_h == 0, "R2 R10 line sync layout", e_h, 0);
    chk(e_v == 0, "R3 R10 frame sync layout", e_v, 0);
    chk(e_de == 0, "R4 data-enable layout", e_de, 0);
    if (c.ppl_x || c.lpp_x) chk(de_cnt == ha * va, "R5 extended active count", de_cnt, ha * va);
    else                    chk(de_cnt == ha * va, "R4 active count", de_cnt, ha * va);
    chk(e_se == 0, "R7 frame strobes", e_se, 0);

    @(negedge clk);
    chk(done == 1'b1, "R8 done after last pixel", int'(done), 1);
    for (int k = 0; k < 2 * eff + 2; k++) begin
      if (pix_en || de) extra++;
      @(negedge clk);
    end
    chk(extra == 0, "R8 quiet after stop", extra, 0);
    chk({pclk, hsync, vsync} == c.inv, "R6 stopped levels", int'({pclk, hsync, vsync}), int'(c.inv));
    chk(done == 1'b1, "R9 done sticky", int'(done), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!pix_en && !de && !sof && !eof && !done, "R11 reset state",
        int'({pix_en, de, sof, eof, done}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!pix_en && !de && !done && !hsync && !vsync, "R11 after release",
        int'({pix_en, de, done, hsync, vsync}), 0);

    for (int i = 0; i < NVEC; i++) run_vec(i);

    // R9 directed: clear pulse
    @(negedge clk);
    done_clr = 1'b1;
    @(negedge clk);
    done_clr = 1'b0;
    chk(done == 1'b0, "R9 directed clear", int'(done), 0);
    repeat (4) @(negedge clk);
    chk(done == 1'b0 && !pix_en, "R9 stays clear while stopped", int'(done), 0);

    // R11 directed: reset during a run
    raster_en = 1'b1;
    repeat (20) @(negedge clk);
    rst_n = 1'b0;
    raster_en = 1'b0;
    @(negedge clk);
    chk(!pix_en && !de && !sof && !eof && !done, "R11 reset mid-run",
        int'({pix_en, de, sof, eof, done}), 0);
    rst_n = 1'b1;

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL R8 watchdog expired actual=%0d expected=0", WD_CYCLES);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule